// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block sits between a UART receiver and its receive FIFO. It examines every character the receiver delivers and applies in-band software flow control to the local transmitter. A programmable pause code and a programmable resume code can each be a single character or an ordered pair of characters. When the pause code or pair arrives, the block raises `tx_pause`. The transmit serializer finishes the character it is shifting out and then holds off. When the resume code or pair arrives, `tx_pause` drops again. Characters that complete a match are consumed. All other characters go on to the FIFO through a one-cycle forwarding stage.

There are two optional modes. In resume-on-any mode, any character received while paused ends the pause. In that mode a first resume code is consumed, and whatever follows it, including a second resume code, is ordinary data. In special-character mode, every character is compared with the second pause code. A hit raises the flow-control interrupt but leaves the transmitter running, and the character is still forwarded. The interrupt status drives an active-low request line. A host read of the interrupt identification register clears it, and so does a resume.

The character input is a valid/data stream with no ready. The detector accepts one character in every cycle that `rx_valid` is high and never applies back-pressure. The forwarding output has no ready either, so the FIFO must take every `fwd_valid` beat. Control inputs are plain levels, and `iir_read` is a one-cycle strobe.

Top module: `uart_swflow_det`

## Requirements
- R1: A synchronous active-high `rst` clears the pause state, the pair tracker and the interrupt status. From the cycle after reset, `tx_pause`=0, `flow_int`=0, `irq_n`=1 and `fwd_valid`=0.
- R2: With `sw_en`=1 and `pair_mode`=0, a character equal to `xoff1` sets `tx_pause` from the next cycle and is not forwarded.
- R3: With `pair_mode`=1, `xoff1` followed by `xoff2` as consecutive accepted characters sets `tx_pause`. Idle cycles between them are allowed. The `xoff1` is forwarded and the completing `xoff2` is consumed.
- R4: In pair mode, any character other than the expected second code that arrives after a first code discards the partial match. A repeated first code starts a fresh match.
- R5: A resume match clears `tx_pause` and `flow_int` from the next cycle, and the completing character is not forwarded. The match is `xon1` alone when `pair_mode`=0, or `xon1` then `xon2` when `pair_mode`=1.
- R6: A pause match sets `flow_int` only when `int_en`=1. `irq_n` is always the inverse of `flow_int`.
- R7: With `any_resume`=1 while paused, any accepted character clears `tx_pause`. That character is forwarded unless it equals `xon1`, and the tracker returns to idle, so a following `xon2` is forwarded.
- R8: With `special_en`=1, a character equal to `xoff2` that does not complete a pause pair sets `flow_int` (when `int_en`=1). It leaves `tx_pause` unchanged and is forwarded.
- R9: `iir_read` clears `flow_int` on the next cycle. If a new interrupt event arrives in the same cycle, the set wins.
- R10: With `sw_en`=0, `tx_pause` is 0, the tracker is idle and every accepted character is forwarded.
- R11: For each character that is not consumed, `fwd_valid` is high with `fwd_data` equal to that character exactly one cycle after it is accepted. `fwd_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received character present this cycle |
| rx_data | input | DW | Received character |
| sw_en | input | 1 | Software flow control enable |
| pair_mode | input | 1 | Pause and resume codes are two-character pairs |
| any_resume | input | 1 | Any character ends a pause |
| special_en | input | 1 | Interrupt on `xoff2` without pausing |
| int_en | input | 1 | Flow-control interrupt enable |
| iir_read | input | 1 | Host read strobe of interrupt identification |
| xon1 | input | DW | First resume code |
| xon2 | input | DW | Second resume code |
| xoff1 | input | DW | First pause code |
| xoff2 | input | DW | Second pause code / special character |
| tx_pause | output | 1 | Hold transmitter after current character |
| flow_int | output | 1 | Flow-control interrupt status |
| irq_n | output | 1 | Interrupt request, active low |
| fwd_valid | output | 1 | Character written to RX FIFO |
| fwd_data | output | DW | Forwarded character |

## Verification
On every cycle the assertions check several local properties. A lone pause code in single mode always leads to `tx_pause`. The interrupt status can only rise while its enable was high. A disabled detector passes every character straight through unchanged. A special-character hit raises the interrupt without pausing. The pair sequencing cannot be shown that way. This covers broken sequences, a repeated first code and idle gaps inside a pair. It also covers the resume-on-any interaction, where a consumed `xon1` lets the following `xon2` through as data, and an interrupt-register read that collides with a new event. Those are shown only by the bench scenarios, which compare every output against a behavioural model each cycle.

// File: rtl/uart_swflow_pkg.sv
package uart_swflow_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_OFF1 = 2'd1,
    TRK_ON1  = 2'd2
  } trk_e;

  localparam int NCODE   = 4;
  localparam int IDX_ON1  = 0;
  localparam int IDX_ON2  = 1;
  localparam int IDX_OFF1 = 2;
  localparam int IDX_OFF2 = 3;
endpackage

// File: rtl/uart_swflow_match.sv
module uart_swflow_match
  import uart_swflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]            chr,
  input  logic [NCODE-1:0][DW-1:0] codes,
  output logic [NCODE-1:0]         hit
);
  for (genvar g = 0; g < NCODE; g++) begin : g_cmp
    assign hit[g] = (chr == codes[g]);
  end
endmodule

// File: rtl/uart_swflow_seq.sv
module uart_swflow_seq
  import uart_swflow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             sw_en,
  input  logic             pair_mode,
  input  logic             any_resume,
  input  logic             special_en,
  input  logic [NCODE-1:0] hit,
  output logic             paused,
  output logic             consume,
  output logic             ev_pause,
  output logic             ev_resume,
  output logic             ev_special
);
  trk_e trk_q, trk_d;
  logic paused_d;
  logic wake_any, off_done, on_done;

  always_comb begin
    wake_any = valid && sw_en && any_resume && paused;
    if (pair_mode) begin
      off_done = valid && sw_en && (trk_q == TRK_OFF1) && hit[IDX_OFF2];
      on_done  = valid && sw_en && (trk_q == TRK_ON1)  && hit[IDX_ON2];
    end else begin
      off_done = valid && sw_en && hit[IDX_OFF1];
      on_done  = valid && sw_en && hit[IDX_ON1];
    end

    trk_d    = trk_q;
    paused_d = paused;
    consume  = 1'b0;
    if (!sw_en) begin
      trk_d    = TRK_IDLE;
      paused_d = 1'b0;
    end else if (valid) begin
      if (wake_any) begin
        paused_d = 1'b0;
        consume  = hit[IDX_ON1];
        trk_d    = TRK_IDLE;
      end else if (off_done) begin
        paused_d = 1'b1;
        consume  = 1'b1;
        trk_d    = TRK_IDLE;
      end else if (on_done) begin
        paused_d = 1'b0;
        consume  = 1'b1;
        trk_d    = TRK_IDLE;
      end else if (pair_mode && hit[IDX_OFF1]) begin
        trk_d = TRK_OFF1;
      end else if (pair_mode && hit[IDX_ON1]) begin
        trk_d = TRK_ON1;
      end else begin
        trk_d = TRK_IDLE;
      end
    end

    ev_pause   = off_done && !wake_any;
    ev_resume  = wake_any || (on_done && !off_done);
    ev_special = valid && special_en && hit[IDX_OFF2] && !ev_pause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_q  <= TRK_IDLE;
      paused <= 1'b0;
    end else begin
      trk_q  <= trk_d;
      paused <= paused_d;
    end
  end
endmodule

// File: rtl/uart_swflow_irq.sv
module uart_swflow_irq (
  input  logic clk,
  input  logic rst,
  input  logic int_en,
  input  logic ev_set,
  input  logic ev_clear,
  input  logic iir_read,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                       flag <= 1'b0;
    else if (int_en && ev_set)     flag <= 1'b1;
    else if (iir_read || ev_clear) flag <= 1'b0;
  end
endmodule

// File: rtl/uart_swflow_det.sv
module uart_swflow_det
  import uart_swflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          sw_en,
  input  logic          pair_mode,
  input  logic          any_resume,
  input  logic          special_en,
  input  logic          int_en,
  input  logic          iir_read,
  input  logic [DW-1:0] xon1,
  input  logic [DW-1:0] xon2,
  input  logic [DW-1:0] xoff1,
  input  logic [DW-1:0] xoff2,
  output logic          tx_pause,
  output logic          flow_int,
  output logic          irq_n,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data
);
  logic [NCODE-1:0][DW-1:0] codes;
  logic [NCODE-1:0]         hit;
  logic consume, ev_pause, ev_resume, ev_special;

  always_comb begin
    codes[IDX_ON1]  = xon1;
    codes[IDX_ON2]  = xon2;
    codes[IDX_OFF1] = xoff1;
    codes[IDX_OFF2] = xoff2;
  end

  uart_swflow_match #(.DW(DW)) match_i (
    .chr(rx_data), .codes(codes), .hit(hit)
  );

  uart_swflow_seq seq_i (
    .clk(clk), .rst(rst), .valid(rx_valid), .sw_en(sw_en),
    .pair_mode(pair_mode), .any_resume(any_resume), .special_en(special_en),
    .hit(hit), .paused(tx_pause), .consume(consume),
    .ev_pause(ev_pause), .ev_resume(ev_resume), .ev_special(ev_special)
  );

  uart_swflow_irq irq_i (
    .clk(clk), .rst(rst), .int_en(int_en),
    .ev_set(ev_pause || ev_special), .ev_clear(ev_resume),
    .iir_read(iir_read), .flag(flow_int)
  );

  assign irq_n = !flow_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= rx_valid && !consume;
      if (rx_valid) fwd_data <= rx_data;
    end
  end
endmodule

// File: rtl/uart_swflow_det_chk.sv
module uart_swflow_det_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          sw_en,
  input logic          pair_mode,
  input logic          any_resume,
  input logic          special_en,
  input logic          int_en,
  input logic [DW-1:0] xoff1,
  input logic [DW-1:0] xoff2,
  input logic          tx_pause,
  input logic          flow_int,
  input logic          fwd_valid,
  input logic [DW-1:0] fwd_data
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tx_pause && !flow_int && !fwd_valid));

  // R2
  single_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !pair_mode && rx_valid && rx_data == xoff1 && !(any_resume && tx_pause))
      |=> (tx_pause && !fwd_valid));

  // R6
  int_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flow_int) |-> $past(int_en));

  // R8
  special_no_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && special_en && int_en && rx_valid && rx_data == xoff2)
      |=> (flow_int && !tx_pause && fwd_valid));

  // R10
  disabled_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && rx_valid) |=> (fwd_valid && fwd_data == $past(rx_data) && !tx_pause));

  // R11
  fwd_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(rx_valid));
endmodule

bind uart_swflow_det uart_swflow_det_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
  .sw_en(sw_en), .pair_mode(pair_mode), .any_resume(any_resume),
  .special_en(special_en), .int_en(int_en), .xoff1(xoff1), .xoff2(xoff2),
  .tx_pause(tx_pause), .flow_int(flow_int), .fwd_valid(fwd_valid),
  .fwd_data(fwd_data)
);

// File: tb/uart_swflow_det_tb_top.sv
`timescale 1ns/1ps
module uart_swflow_det_tb_top;
  localparam int DW = 8;
  localparam logic [7:0] C_ON1 = 8'h11, C_ON2 = 8'h12, C_OFF1 = 8'h13, C_OFF2 = 8'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic sw_en = 1'b0, pair_mode = 1'b0, any_resume = 1'b0, special_en = 1'b0;
  logic int_en = 1'b0, iir_read = 1'b0;
  logic tx_pause, flow_int, irq_n, fwd_valid;
  logic [DW-1:0] fwd_data;

  always #4 clk = ~clk;

  uart_swflow_det #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .sw_en(sw_en), .pair_mode(pair_mode), .any_resume(any_resume),
    .special_en(special_en), .int_en(int_en), .iir_read(iir_read),
    .xon1(C_ON1), .xon2(C_ON2), .xoff1(C_OFF1), .xoff2(C_OFF2),
    .tx_pause(tx_pause), .flow_int(flow_int), .irq_n(irq_n),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference: pending pair as a small integer, the rest as bits
  int  m_pend = 0;  // 0 none, 1 after xoff1, 2 after xon1
  bit  m_pause = 0, m_int = 0, m_fv = 0;
  logic [7:0] m_fd = '0;

  always @(posedge clk) begin
    bit cons, setev, clrev, wake, offm, onm;
    started = 1;
    cyc++;
    if (rst) begin
      m_pend = 0; m_pause = 0; m_int = 0; m_fv = 0;
    end else begin
      cons = 0; setev = 0; clrev = 0;
      wake = rx_valid && sw_en && any_resume && m_pause;
      offm = rx_valid && sw_en && (pair_mode ? (m_pend == 1 && rx_data == C_OFF2) : rx_data == C_OFF1);
      onm  = rx_valid && sw_en && (pair_mode ? (m_pend == 2 && rx_data == C_ON2) : rx_data == C_ON1);
      if (!sw_en) begin
        m_pend = 0; m_pause = 0;
      end else if (rx_valid) begin
        if (wake) begin
          m_pause = 0; clrev = 1; cons = (rx_data == C_ON1); m_pend = 0;
        end else if (offm) begin
          m_pause = 1; setev = 1; cons = 1; m_pend = 0;
        end else if (onm) begin
          m_pause = 0; clrev = 1; cons = 1; m_pend = 0;
        end else if (pair_mode && rx_data == C_OFF1) m_pend = 1;
        else if (pair_mode && rx_data == C_ON1) m_pend = 2;
        else m_pend = 0;
      end
      if (rx_valid && special_en && rx_data == C_OFF2 && !setev) setev = 1;
      if (int_en && setev) m_int = 1;
      else if (iir_read || clrev) m_int = 0;
      m_fv = rx_valid && !cons;
      if (rx_valid) m_fd = rx_data;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk1("tx_pause", tx_pause, m_pause);
      chk1("flow_int", flow_int, m_int);
      chk1("irq_n", irq_n, !m_int);
      chk1("fwd_valid", fwd_valid, m_fv);
      if (m_fv) begin
        checks++;
        if (fwd_data !== m_fd) begin
          fails++;
          $display("FAIL %s fwd_data: actual %02h expected %02h", cur_req, fwd_data, m_fd);
        end
      end
    end
  end

  task automatic send(logic [7:0] c);
    rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    cur_req = "R1"; idle(2);

    cur_req = "R10";
    send(C_OFF1); send(C_ON1); send(8'h41); idle(1);

    cur_req = "R2"; sw_en = 1; int_en = 1;
    send(8'h41); send(C_OFF1); send(8'h42); idle(2);
    cur_req = "R5"; send(C_ON1); idle(1);

    cur_req = "R6"; int_en = 0;
    send(C_OFF1); idle(1); send(C_ON1); int_en = 1; idle(1);

    cur_req = "R3"; pair_mode = 1;
    send(C_OFF1); idle(2); send(C_OFF2); idle(1);
    cur_req = "R5"; send(C_ON1); send(C_ON2); idle(1);

    cur_req = "R4";
    send(C_OFF1); send(8'h78); send(C_OFF2); idle(1);
    send(C_OFF1); send(C_OFF1); send(C_OFF2); idle(1);
    send(C_ON1); send(C_OFF1); send(C_ON2); idle(1);
    send(C_ON1); send(C_ON2); idle(1);

    cur_req = "R7"; any_resume = 1;
    send(C_OFF1); send(C_OFF2); idle(1);
    send(C_ON1); send(C_ON2); idle(1);
    send(C_OFF1); send(C_OFF2); send(8'h5A); idle(1);
    any_resume = 0;

    cur_req = "R8"; pair_mode = 0; special_en = 1;
    send(C_OFF2); idle(2);
    cur_req = "R9"; iir_read = 1; @(negedge clk); iir_read = 0; idle(1);
    iir_read = 1; send(C_OFF2); iir_read = 0; idle(1);
    iir_read = 1; @(negedge clk); iir_read = 0;
    cur_req = "R8"; sw_en = 0; send(C_OFF2); idle(1);
    int_en = 0; send(C_OFF2); idle(1);

    cur_req = "R11"; sw_en = 1; int_en = 1; special_en = 0;
    send(8'h00); send(8'hFF); send(C_ON2); idle(2);

    cur_req = "R1"; send(C_OFF1); rst = 1; idle(2); rst = 0; idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule